// File: doc/BRIEF.md
# Interrupt Aggregator

This block collects three groups of event flags (four transmit events, eight receive events split over two receive channels, and one wake event) and merges them into a single interrupt request output. Each group has a sticky status register and an enable register, reached through a simple single-cycle register read/write port. Software either waits on the interrupt request or polls the status registers. Reading a status register clears it.

A mode input chooses between transmit and receive operation. The group for the unused direction is kept from raising the request, but its enable bits stay as they were written. A configuration bit picks the active level of the request. The output is modelled as a level plus an output-enable, so an active-low request behaves as an open-drain pin and an active-high request behaves as an open-source pin.

Register addresses (3-bit): 0 configuration (bit 0 = active-high), 1 transmit enable, 2 transmit status, 3 receive enable, 4 receive status, 5 wake enable, 6 wake status. Address 7 is unused.

Top module: `irq_aggregator`

## Requirements
- R1: Writing address 1, 3 or 5 stores the low 4, 8 or 1 bits of the write data as the transmit, receive or wake enable. Writing address 0 stores bit 0 as the polarity. A read returns the stored bits, and unused upper bits read as 0.
- R2: A high on bit i of `txEvent`, `rxEvent` or `wakeEvent` during a clock edge sets status bit i of that group (addresses 2, 4, 6). The bit stays set until it is cleared, and it is set whatever the value of the enable bit.
- R3: A read of a status address returns the status held before that clock edge and then clears the whole register.
- R4: The request is active while some status bit is set together with its enable bit, in a group the mode allows, and inactive otherwise.
- R5: With `txMode`=1 the receive group cannot raise the request. With `txMode`=0 the transmit group cannot raise it. The wake group is never masked.
- R6: Changing `txMode` leaves the stored contents of every enable register unchanged.
- R7: While the request is active, `irqOe`=1 and `irqOut` equals the polarity bit (1 = active-high, open-source; 0 = active-low, open-drain). While it is inactive, `irqOe`=0.
- R8: Writes to status addresses or to address 7 change no register. Reads of address 7, or any read with `regRe`=0, return 0.
- R9: After reset, all enables, all status bits and the polarity bit are 0, and `irqOe`=0.
- R10: An event that arrives in the same cycle as a read of its status register is kept set after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (clears status on read) |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, valid in the cycle of `regRe` |
| txMode | input | 1 | 1 = transmit mode, 0 = receive mode |
| txEvent | input | 4 | Transmit event pulses |
| rxEvent | input | 8 | Receive event pulses (channel A low nibble, B high nibble) |
| wakeEvent | input | 1 | Wake (oscillator ready) event pulse |
| irqOut | output | 1 | Pin level driven while enabled |
| irqOe | output | 1 | Pin output enable (request active) |

## Verification
The transmit group is swept over every pairing of a 4-bit enable mask and a 4-bit event pattern, in both modes. This separates a correct AND-then-OR reduction from masking errors, and shows that status is captured regardless of enable. The receive group is swept over all 256 enable masks, each paired with an arithmetic event pattern, again in both modes. The wake group is swept over all enable, event and mode combinations. Directed sequences then cover both polarities at the pin, the clear-on-read race, enable retention across mode changes, and ignored writes and reads.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_CFG  = 0;
  localparam int ADDR_TXEN = 1;
  localparam int ADDR_TXST = 2;
  localparam int ADDR_RXEN = 3;
  localparam int ADDR_RXST = 4;
  localparam int ADDR_WKEN = 5;
  localparam int ADDR_WKST = 6;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CFG, SEL_TXEN, SEL_TXST, SEL_RXEN, SEL_RXST, SEL_WKEN, SEL_WKST
  } rdSel_e;

  typedef struct packed {
    logic   cfgWr;
    logic   txEnWr;
    logic   rxEnWr;
    logic   wakeEnWr;
    logic   txClr;
    logic   rxClr;
    logic   wakeClr;
    rdSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_group.sv
module irq_group #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enWr,
  input  logic [N-1:0] enData,
  input  logic         clr,
  input  logic [N-1:0] srcEvt,
  input  logic         allow,
  output logic [N-1:0] enable,
  output logic [N-1:0] status,
  output logic         pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
      status <= '0;
    end else begin
      if (enWr) enable <= enData;
      // events are OR-ed in after the clear so a racing event survives
      status <= (clr ? '0 : status) | srcEvt;
    end
  end

  assign pending = allow & (|(status & enable));
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobe_t       strobe
);
  always_comb begin
    strobe = '0;
    if (regWe) begin
      strobe.cfgWr    = (regAddr == ADDR_W'(ADDR_CFG));
      strobe.txEnWr   = (regAddr == ADDR_W'(ADDR_TXEN));
      strobe.rxEnWr   = (regAddr == ADDR_W'(ADDR_RXEN));
      strobe.wakeEnWr = (regAddr == ADDR_W'(ADDR_WKEN));
    end
    if (regRe) begin
      strobe.txClr   = (regAddr == ADDR_W'(ADDR_TXST));
      strobe.rxClr   = (regAddr == ADDR_W'(ADDR_RXST));
      strobe.wakeClr = (regAddr == ADDR_W'(ADDR_WKST));
      case (regAddr)
        ADDR_W'(ADDR_CFG):  strobe.rdSel = SEL_CFG;
        ADDR_W'(ADDR_TXEN): strobe.rdSel = SEL_TXEN;
        ADDR_W'(ADDR_TXST): strobe.rdSel = SEL_TXST;
        ADDR_W'(ADDR_RXEN): strobe.rdSel = SEL_RXEN;
        ADDR_W'(ADDR_RXST): strobe.rdSel = SEL_RXST;
        ADDR_W'(ADDR_WKEN): strobe.rdSel = SEL_WKEN;
        ADDR_W'(ADDR_WKST): strobe.rdSel = SEL_WKST;
        default:            strobe.rdSel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TX_N   = 4,
  parameter int RX_N   = 8,
  parameter int WAKE_N = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] wdata,
  input  logic              txMode,
  input  logic [TX_N-1:0]   txEvent,
  input  logic [RX_N-1:0]   rxEvent,
  input  logic [WAKE_N-1:0] wakeEvent,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut,
  output logic              irqOe,
  output logic [TX_N-1:0]   txEnable,
  output logic [TX_N-1:0]   txStatus,
  output logic [RX_N-1:0]   rxEnable,
  output logic [RX_N-1:0]   rxStatus,
  output logic [WAKE_N-1:0] wakeEnable,
  output logic [WAKE_N-1:0] wakeStatus,
  output logic              cfgActiveHigh
);
  logic txPend, rxPend, wakePend;

  irq_group #(.N(TX_N)) u_txGroup (
    .clk(clk), .rst_n(rst_n), .enWr(strobe.txEnWr), .enData(wdata[TX_N-1:0]),
    .clr(strobe.txClr), .srcEvt(txEvent), .allow(txMode),
    .enable(txEnable), .status(txStatus), .pending(txPend));

  irq_group #(.N(RX_N)) u_rxGroup (
    .clk(clk), .rst_n(rst_n), .enWr(strobe.rxEnWr), .enData(wdata[RX_N-1:0]),
    .clr(strobe.rxClr), .srcEvt(rxEvent), .allow(!txMode),
    .enable(rxEnable), .status(rxStatus), .pending(rxPend));

  irq_group #(.N(WAKE_N)) u_wakeGroup (
    .clk(clk), .rst_n(rst_n), .enWr(strobe.wakeEnWr), .enData(wdata[WAKE_N-1:0]),
    .clr(strobe.wakeClr), .srcEvt(wakeEvent), .allow(1'b1),
    .enable(wakeEnable), .status(wakeStatus), .pending(wakePend));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cfgActiveHigh <= 1'b0;
    else if (strobe.cfgWr) cfgActiveHigh <= wdata[0];
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_CFG:  rdata = DATA_W'(cfgActiveHigh);
      SEL_TXEN: rdata = DATA_W'(txEnable);
      SEL_TXST: rdata = DATA_W'(txStatus);
      SEL_RXEN: rdata = DATA_W'(rxEnable);
      SEL_RXST: rdata = DATA_W'(rxStatus);
      SEL_WKEN: rdata = DATA_W'(wakeEnable);
      SEL_WKST: rdata = DATA_W'(wakeStatus);
      default:  rdata = '0;
    endcase
  end

  // polarity is applied after the OR: drive the active level only when asserting
  assign irqOe  = txPend | rxPend | wakePend;
  assign irqOut = cfgActiveHigh;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int TX_N   = 4,
  parameter int RX_N   = 8,
  parameter int WAKE_N = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              txMode,
  input  logic [TX_N-1:0]   txEvent,
  input  logic [RX_N-1:0]   rxEvent,
  input  logic [WAKE_N-1:0] wakeEvent,
  output logic              irqOut,
  output logic              irqOe
);
  ctrlStrobe_t       strobe;
  logic [TX_N-1:0]   txEnable, txStatus;
  logic [RX_N-1:0]   rxEnable, rxStatus;
  logic [WAKE_N-1:0] wakeEnable, wakeStatus;
  logic              cfgActiveHigh;

  irq_agg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr), .strobe(strobe));

  irq_agg_datapath #(.DATA_W(DATA_W), .TX_N(TX_N), .RX_N(RX_N), .WAKE_N(WAKE_N)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wdata(regWdata), .txMode(txMode),
    .txEvent(txEvent), .rxEvent(rxEvent), .wakeEvent(wakeEvent),
    .rdata(regRdata), .irqOut(irqOut), .irqOe(irqOe),
    .txEnable(txEnable), .txStatus(txStatus), .rxEnable(rxEnable), .rxStatus(rxStatus),
    .wakeEnable(wakeEnable), .wakeStatus(wakeStatus), .cfgActiveHigh(cfgActiveHigh));
endmodule

// File: rtl/irq_aggregator_checker.sv
module irq_aggregator_checker
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int TX_N   = 4,
  parameter int RX_N   = 8,
  parameter int WAKE_N = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              regWe,
  input logic              regRe,
  input logic [ADDR_W-1:0] regAddr,
  input logic              txMode,
  input logic [TX_N-1:0]   txEvent,
  input logic [RX_N-1:0]   rxEvent,
  input logic [WAKE_N-1:0] wakeEvent,
  input logic              irqOut,
  input logic              irqOe,
  input logic [TX_N-1:0]   txEnable,
  input logic [TX_N-1:0]   txStatus,
  input logic [RX_N-1:0]   rxEnable,
  input logic [RX_N-1:0]   rxStatus,
  input logic [WAKE_N-1:0] wakeEnable,
  input logic [WAKE_N-1:0] wakeStatus,
  input logic              cfgActiveHigh
);
  assert_rx_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rxEvent != '0) |=> ((rxStatus & $past(rxEvent)) == $past(rxEvent)));

  assert_tx_event_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (txEvent != '0) |=> ((txStatus & $past(txEvent)) == $past(txEvent)));

  assert_tx_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (regRe && regAddr == ADDR_W'(ADDR_TXST) && txEvent == '0) |=> (txStatus == '0));

  assert_wake_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (regRe && regAddr == ADDR_W'(ADDR_WKST) && wakeEvent == '0) |=> (wakeStatus == '0));

  assert_enable_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !regWe |=> ($stable(txEnable) && $stable(rxEnable) && $stable(wakeEnable)));

  assert_rx_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (txMode && (txStatus & txEnable) == '0 && (wakeStatus & wakeEnable) == '0) |-> !irqOe);

  assert_tx_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!txMode && (rxStatus & rxEnable) == '0 && (wakeStatus & wakeEnable) == '0) |-> !irqOe);

  assert_wake_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((wakeStatus & wakeEnable) != '0) |-> irqOe);

  assert_pin_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irqOe |-> (irqOut == cfgActiveHigh));
endmodule

bind irq_aggregator irq_aggregator_checker #(
  .ADDR_W(ADDR_W), .TX_N(TX_N), .RX_N(RX_N), .WAKE_N(WAKE_N)
) u_chk (
  .clk(clk), .rst_n(rst_n), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
  .txMode(txMode), .txEvent(txEvent), .rxEvent(rxEvent), .wakeEvent(wakeEvent),
  .irqOut(irqOut), .irqOe(irqOe), .txEnable(txEnable), .txStatus(txStatus),
  .rxEnable(rxEnable), .rxStatus(rxStatus), .wakeEnable(wakeEnable),
  .wakeStatus(wakeStatus), .cfgActiveHigh(cfgActiveHigh));

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       regWe = 1'b0, regRe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       txMode = 1'b0;
  logic [3:0] txEvent = '0;
  logic [7:0] rxEvent = '0;
  logic [0:0] wakeEvent = '0;
  logic       irqOut, irqOe;

  int total = 0, bad = 0;
  bit finished = 0;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .txMode(txMode), .txEvent(txEvent),
    .rxEvent(rxEvent), .wakeEvent(wakeEvent), .irqOut(irqOut), .irqOe(irqOe));

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); regWe = 1'b1; regAddr = 3'(a); regWdata = 8'(d);
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); regRe = 1'b1; regAddr = 3'(a);
    #1 d = int'(regRdata);
    @(negedge clk); regRe = 1'b0;
  endtask

  task automatic pulse(input int t, input int r, input int w);
    @(negedge clk); txEvent = 4'(t); rxEvent = 8'(r); wakeEvent = 1'(w);
    @(negedge clk); txEvent = '0; rxEvent = '0; wakeEvent = '0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk("R9 irqOe", int'(irqOe), 0);
    for (int a = 0; a < 7; a++) begin rd(a, d); chk("R9 reg", d, 0); end

    // R1 storage and unused bits
    wr(1, 255); rd(1, d); chk("R1 txEn", d, 15);
    wr(3, 165); rd(3, d); chk("R1 rxEn", d, 165);
    wr(5, 255); rd(5, d); chk("R1 wakeEn", d, 1);
    wr(0, 254); rd(0, d); chk("R1 cfg", d, 0);
    wr(0, 255); rd(0, d); chk("R1 cfg", d, 1);
    wr(0, 0);

    // R8 ignored writes and reads
    wr(2, 255); wr(4, 255); wr(6, 255); wr(7, 0);
    rd(2, d); chk("R8 txSt", d, 0);
    rd(4, d); chk("R8 rxSt", d, 0);
    rd(6, d); chk("R8 wkSt", d, 0);
    rd(7, d); chk("R8 addr7", d, 0);
    rd(1, d); chk("R8 txEn kept", d, 15);
    rd(3, d); chk("R8 rxEn kept", d, 165);
    pulse(15, 0, 0);
    regAddr = 3'd2; #1 chk("R8 no read", int'(regRdata), 0);
    rd(2, d); chk("R2 tx", d, 15);

    // R6 enables survive mode changes
    txMode = 1'b1; @(negedge clk); txMode = 1'b0; @(negedge clk); txMode = 1'b1;
    rd(1, d); chk("R6 txEn", d, 15);
    rd(3, d); chk("R6 rxEn", d, 165);
    rd(5, d); chk("R6 wakeEn", d, 1);
    wr(5, 0);

    // R4 R5 R2 R3 transmit sweep
    for (int m = 0; m < 2; m++) begin
      txMode = 1'(m);
      for (int e = 0; e < 16; e++) begin
        for (int p = 0; p < 16; p++) begin
          wr(1, e);
          pulse(p, 0, 0);
          chk("R4 R5 tx irq", int'(irqOe), (m == 1 && (e & p) != 0) ? 1 : 0);
          rd(2, d); chk("R2 tx status", d, p);
          chk("R3 tx cleared", int'(irqOe), 0);
        end
      end
    end
    wr(1, 0);

    // receive sweep
    for (int m = 0; m < 2; m++) begin
      txMode = 1'(m);
      for (int e = 0; e < 256; e++) begin
        int p;
        p = (e * 73 + 29) & 255;
        wr(3, e);
        pulse(0, p, 0);
        chk("R4 R5 rx irq", int'(irqOe), (m == 0 && (e & p) != 0) ? 1 : 0);
        rd(4, d); chk("R2 rx status", d, p);
        chk("R3 rx cleared", int'(irqOe), 0);
      end
    end
    wr(3, 0);

    // wake sweep: never masked
    for (int m = 0; m < 2; m++) begin
      txMode = 1'(m);
      for (int e = 0; e < 2; e++) begin
        for (int p = 0; p < 2; p++) begin
          wr(5, e);
          pulse(0, 0, p);
          chk("R5 wake irq", int'(irqOe), e & p);
          rd(6, d); chk("R3 wake status", d, p);
        end
      end
    end

    // R7 polarity and drive
    wr(5, 1); pulse(0, 0, 1);
    chk("R7 low oe", int'(irqOe), 1);
    chk("R7 low level", int'(irqOut), 0);
    wr(0, 1);
    chk("R7 high oe", int'(irqOe), 1);
    chk("R7 high level", int'(irqOut), 1);
    rd(6, d);
    chk("R7 idle oe", int'(irqOe), 0);
    wr(0, 0); wr(5, 0);

    // R10 event racing a clear-on-read
    pulse(1, 0, 0);
    @(negedge clk); regRe = 1'b1; regAddr = 3'd2; txEvent = 4'd2;
    #1 chk("R10 read value", int'(regRdata), 1);
    @(negedge clk); regRe = 1'b0; txEvent = '0;
    rd(2, d); chk("R10 kept", d, 2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule